// File: doc/BRIEF.md
# Stoppable Clock Group Gate

This block takes one free-running source clock and fans it out as a group of ten bus clocks. Seven of them always obey a stop request. The other three obey it only when their own enrolment bit is set. A stop request comes from either of two places: an active-low external pin, or a run bit that management logic writes through a small synchronous register port. The outputs run only when both agree that they should. A stopped output is parked LOW, and stopping or restarting never produces a shortened pulse.

The external pin is asynchronous to the source clock, so it passes through a two-flop synchroniser first. The combined run decision is then captured on the falling edge of the source clock by one enable flop per output. Each output is the source clock ANDed with its own enable, so every gated output stops and restarts on the same source cycle. A read of the control register returns the effective run state and not the stored bit. Software can therefore see whether the group is actually stopped, whatever the cause.

Top module: `clk_stop_group`

## Requirements
- R1: The stoppable outputs run only while the synchronised stop pin is HIGH and the run bit (address 0, bit 0) is 1. If either is low, they stop, and raising only one of the two does not restart them.
- R2: A stopped output is held at logic 0 through both phases of the source clock.
- R3: A read of address 0 returns, in bit 0, the AND of the synchronised pin and the stored run bit, with all other bits 0. It reads 0 while the pin is low even if 1 was written. Read data is registered at the rising edge that samples `rd_en`.
- R4: When the pin changes while the run bit is 1, the outputs are unchanged at the first and second rising edges of `clk_src` after the change. They take the new state from the third rising edge on. All enrolled outputs do this on the same cycle.
- R5: A write to the run bit, accepted at a rising edge, leaves the outputs unchanged in the high phase that starts at that edge. They take the new state from the next rising edge on.
- R6: Address 1, bits 2:0, enrol the three selectable outputs (bit i controls `opt_clk_o[i]`). A 1 makes the output obey the stop request; a 0 keeps it free-running. The field reads back in place, and a change takes effect with the same timing as R5.
- R7: Reset is active low and asynchronous. While it is asserted and afterwards, the run bit is 1, the enrolment bits are 0, and every output follows the source clock.
- R8: The enable of each output changes only while the source clock is LOW. Every output high phase is therefore complete: HIGH from the rising edge until the falling edge.
- R9: Writes to addresses other than 0 and 1 change nothing, and reads of them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Free-running source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req_n | input | 1 | Asynchronous active-low stop pin |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W (2) | Register address |
| wdata | input | DATA_W (8) | Write data |
| rdata | output | DATA_W (8) | Registered read data |
| bus_clk_o | output | N_FIXED (7) | Always-stoppable gated clocks |
| opt_clk_o | output | N_OPT (3) | Clocks with selectable stop enrolment |

## Verification
The bench goes after the cycle at which the group stops and restarts for a pin edge and for a register write, and the two latencies differ. A missing or extra synchroniser stage, or an enable taken on the rising edge, moves the expected cycle or clips a high phase. It holds one control low while it raises the other, which catches a design that combines the controls with OR. A stop pin that is ignored, or an output that parks HIGH, shows up in the same test. It reads the control bit while the pin alone is low; a design that returns the stored bit would answer 1 there. It also changes the enrolment bits while the group is stopped, which catches inverted mask polarity and a selectable output left stuck in the wrong state.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;
  localparam int unsigned CG_ADDR_W = 2;
  localparam int unsigned CG_DATA_W = 8;
  localparam logic [CG_ADDR_W-1:0] CG_ADDR_CTRL = 2'd0;
  localparam logic [CG_ADDR_W-1:0] CG_ADDR_ENROL = 2'd1;

  // Run only when the pin (active-low stop) and the stored run bit both allow it.
  function automatic logic cg_combine_run(input logic pin_run, input logic reg_run);
    return pin_run & reg_run;
  endfunction

  // A selectable output runs when the group runs or when it is not enrolled.
  function automatic logic cg_opt_run(input logic group_run, input logic enrolled);
    return group_run | ~enrolled;
  endfunction
endpackage

// File: rtl/cg_sync.sv
module cg_sync #(
  parameter int unsigned STAGES = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= {chain_q[STAGES-2:0], d_async};
  end

  assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/cg_regs.sv
module cg_regs
  import clkgate_pkg::*;
#(
  parameter int unsigned ADDR_W = CG_ADDR_W,
  parameter int unsigned DATA_W = CG_DATA_W,
  parameter int unsigned N_OPT  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pin_run,
  output logic              run_eff,
  output logic [N_OPT-1:0]  enrol_q,
  output logic [DATA_W-1:0] rdata
);
  logic run_bit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_bit_q <= 1'b1;
      enrol_q   <= '0;
    end else if (wr_en) begin
      if (addr == ADDR_W'(CG_ADDR_CTRL))  run_bit_q <= wdata[0];
      if (addr == ADDR_W'(CG_ADDR_ENROL)) enrol_q   <= wdata[N_OPT-1:0];
    end
  end

  assign run_eff = cg_combine_run(pin_run, run_bit_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else if (rd_en) begin
      rdata <= '0;
      if (addr == ADDR_W'(CG_ADDR_CTRL))  rdata[0]         <= run_eff;
      if (addr == ADDR_W'(CG_ADDR_ENROL)) rdata[N_OPT-1:0] <= enrol_q;
    end
  end

  // R3: the control read shows the combined state, not the stored bit
  a_r3_readback_effective: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADDR_W'(CG_ADDR_CTRL)) |=> (rdata == DATA_W'($past(run_eff))));

  // R9: unmapped reads return zero
  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr != ADDR_W'(CG_ADDR_CTRL) && addr != ADDR_W'(CG_ADDR_ENROL))
      |=> (rdata == '0));
endmodule

// File: rtl/cg_gate_cell.sv
module cg_gate_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic en_req,
  output logic en_o,
  output logic clk_o
);
  logic en_q;

  // Enable is captured on the falling edge, so it only moves while clk is LOW.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b1;
    else        en_q <= en_req;
  end

  assign en_o  = en_q;
  assign clk_o = clk & en_q;

  // R8: the enable never moves during a high phase
  a_r8_enable_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(en_q) || $past(en_q) == $past(en_req));
endmodule

// File: rtl/clk_stop_group.sv
module clk_stop_group
  import clkgate_pkg::*;
#(
  parameter int unsigned N_FIXED     = 7,
  parameter int unsigned N_OPT       = 3,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ADDR_W      = CG_ADDR_W,
  parameter int unsigned DATA_W      = CG_DATA_W
) (
  input  logic               clk_src,
  input  logic               rst_n,
  input  logic               stop_req_n,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  output logic [N_FIXED-1:0] bus_clk_o,
  output logic [N_OPT-1:0]   opt_clk_o
);
  localparam int unsigned N_ALL = N_FIXED + N_OPT;

  // Named internal events, visible to the assertions below
  logic              pin_run_sync;
  logic              run_eff;
  logic [N_OPT-1:0]  enrol_q;
  logic [N_FIXED-1:0] fix_en;
  logic [N_OPT-1:0]  opt_en;
  logic [N_ALL-1:0]  all_en;

  cg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync (
    .clk    (clk_src),
    .rst_n  (rst_n),
    .d_async(stop_req_n),
    .q_sync (pin_run_sync)
  );

  cg_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_OPT(N_OPT)) u_regs (
    .clk    (clk_src),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .rd_en  (rd_en),
    .addr   (addr),
    .wdata  (wdata),
    .pin_run(pin_run_sync),
    .run_eff(run_eff),
    .enrol_q(enrol_q),
    .rdata  (rdata)
  );

  for (genvar gi = 0; gi < N_FIXED; gi++) begin : g_fixed
    cg_gate_cell u_cell (
      .clk   (clk_src),
      .rst_n (rst_n),
      .en_req(run_eff),
      .en_o  (fix_en[gi]),
      .clk_o (bus_clk_o[gi])
    );
  end

  for (genvar gj = 0; gj < N_OPT; gj++) begin : g_opt
    cg_gate_cell u_cell (
      .clk   (clk_src),
      .rst_n (rst_n),
      .en_req(cg_opt_run(run_eff, enrol_q[gj])),
      .en_o  (opt_en[gj]),
      .clk_o (opt_clk_o[gj])
    );
  end

  assign all_en = {opt_en, fix_en};

  // R1: a stop from either source has reached every fixed output by the next rising edge
  a_r1_stop_reaches_fixed: assert property (@(posedge clk_src) disable iff (!rst_n)
    !run_eff |-> (fix_en == '0));

  // R4: all fixed outputs run together when the group runs
  a_r4_fixed_in_step: assert property (@(posedge clk_src) disable iff (!rst_n)
    run_eff |-> (fix_en == {N_FIXED{1'b1}}));

  // R6: an output that is not enrolled keeps running
  for (genvar gk = 0; gk < N_OPT; gk++) begin : g_opt_chk
    a_r6_unenrolled_runs: assert property (@(posedge clk_src) disable iff (!rst_n)
      !enrol_q[gk] |-> opt_en[gk]);
  end

  // R4: the synchronised pin only rises after the pin was high two edges earlier
  a_r4_sync_delay: assert property (@(posedge clk_src) disable iff (!rst_n)
    $rose(pin_run_sync) |-> $past(stop_req_n, 2));

  // R2: enables are either all on or the stopped ones are exactly the enrolled set
  a_r2_stop_pattern: assert property (@(posedge clk_src) disable iff (!rst_n)
    !run_eff |-> ($countones(all_en) == N_OPT - $countones(enrol_q)));
endmodule

// File: tb/clk_stop_group_tb.sv
module clk_stop_group_tb;
  localparam int NF = 7;
  localparam int NO = 3;

  typedef struct {
    logic [NF-1:0] fix;
    logic [NO-1:0] opt;
    string         tag;
  } exp_t;

  logic       clk_src = 1'b0;
  logic       rst_n = 1'b0;
  logic       stop_req_n = 1'b1;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [NF-1:0] bus_clk_o;
  logic [NO-1:0] opt_clk_o;

  int checks = 0;
  int failures = 0;
  exp_t sb_q[$];

  always #5 clk_src = ~clk_src;

  clk_stop_group u_dut (
    .clk_src(clk_src), .rst_n(rst_n), .stop_req_n(stop_req_n),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .bus_clk_o(bus_clk_o), .opt_clk_o(opt_clk_o)
  );

  localparam logic [NF-1:0] FON = '1;
  localparam logic [NF-1:0] FOFF = '0;

  task automatic push(input logic [NF-1:0] f, input logic [NO-1:0] o, input string tag, input int n);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      e.fix = f; e.opt = o; e.tag = tag;
      sb_q.push_back(e);
    end
  endtask

  task automatic drain();
    while (sb_q.size() != 0) @(negedge clk_src);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk_src);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [7:0] exp, input string tag);
    rd_en = 1'b1; addr = a;
    @(negedge clk_src);
    rd_en = 1'b0;
    checks++;
    if (rdata !== exp) begin
      failures++;
      $display("FAIL %s read addr %0d: actual %h expected %h", tag, a, rdata, exp);
    end
  endtask

  // Monitor: one expected item per rising edge, compared early and late in the high phase.
  always @(posedge clk_src) begin
    if (sb_q.size() != 0) begin
      exp_t e;
      logic [NF-1:0] f1;
      logic [NO-1:0] o1;
      e = sb_q.pop_front();
      #2;
      f1 = bus_clk_o; o1 = opt_clk_o;
      #2;
      checks++;
      if (f1 !== e.fix || o1 !== e.opt || bus_clk_o !== e.fix || opt_clk_o !== e.opt) begin
        failures++;
        $display("FAIL %s/R8 at %0t: actual fix=%b/%b opt=%b/%b expected fix=%b opt=%b",
                 e.tag, $time, f1, bus_clk_o, o1, opt_clk_o, e.fix, e.opt);
      end
      #3;
      checks++;
      if (bus_clk_o !== '0 || opt_clk_o !== '0) begin
        failures++;
        $display("FAIL R2 low phase at %0t: actual fix=%b opt=%b expected all 0",
                 $time, bus_clk_o, opt_clk_o);
      end
    end
  end

  initial begin : watchdog
    #200000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R7: outputs follow the clock while in reset
    repeat (2) @(negedge clk_src);
    #6;
    checks++;
    if (bus_clk_o !== FON || opt_clk_o !== 3'b111) begin
      failures++;
      $display("FAIL R7 in reset: actual fix=%b opt=%b expected all 1", bus_clk_o, opt_clk_o);
    end
    @(negedge clk_src);
    rst_n = 1'b1;
    push(FON, 3'b111, "R7", 3); drain();
    rd_chk(2'd1, 8'h00, "R7");
    rd_chk(2'd0, 8'h01, "R3");

    // R6: enrol outputs 0 and 2
    push(FON, 3'b111, "R6", 3);
    wr(2'd1, 8'h05); drain();
    rd_chk(2'd1, 8'h05, "R6");

    // R4: pin stop takes effect at the third rising edge
    push(FON, 3'b111, "R4", 2);
    push(FOFF, 3'b010, "R4", 4);
    stop_req_n = 1'b0; drain();
    rd_chk(2'd0, 8'h00, "R3");

    // R4: pin release restarts at the third rising edge
    push(FOFF, 3'b010, "R4", 2);
    push(FON, 3'b111, "R4", 3);
    stop_req_n = 1'b1; drain();

    // R5: register stop one edge after the write is accepted
    push(FON, 3'b111, "R5", 1);
    push(FOFF, 3'b010, "R5", 3);
    wr(2'd0, 8'h00); drain();
    rd_chk(2'd0, 8'h00, "R3");

    // R1: pin low, then run bit back to 1: still stopped
    stop_req_n = 1'b0;
    push(FOFF, 3'b010, "R1", 4);
    drain();
    push(FOFF, 3'b010, "R1", 4);
    wr(2'd0, 8'h01); drain();
    rd_chk(2'd0, 8'h00, "R3");

    // R4: pin release with run bit 1 restarts
    push(FOFF, 3'b010, "R4", 2);
    push(FON, 3'b111, "R4", 3);
    stop_req_n = 1'b1; drain();
    rd_chk(2'd0, 8'h01, "R3");

    // R6: enrol only output 1, then stop by register
    push(FON, 3'b111, "R6", 2);
    wr(2'd1, 8'h02); drain();
    push(FON, 3'b111, "R6", 1);
    push(FOFF, 3'b101, "R6", 3);
    wr(2'd0, 8'h00); drain();

    // R6: de-enrol everything while stopped
    push(FOFF, 3'b101, "R6", 1);
    push(FOFF, 3'b111, "R6", 3);
    wr(2'd1, 8'h00); drain();
    push(FOFF, 3'b111, "R5", 1);
    push(FON, 3'b111, "R5", 3);
    wr(2'd0, 8'h01); drain();

    // R9: unmapped writes change nothing, unmapped reads give 0
    push(FON, 3'b111, "R9", 4);
    wr(2'd2, 8'h00);
    wr(2'd3, 8'h00); drain();
    rd_chk(2'd2, 8'h00, "R9");
    rd_chk(2'd3, 8'h00, "R9");
    rd_chk(2'd0, 8'h01, "R9");
    rd_chk(2'd1, 8'h00, "R9");

    repeat (3) @(negedge clk_src);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule